// File: doc/BRIEF.md
# HCI UART with Hardware Flow Control

A full-duplex serial port for a host controller link: eight data bits, no parity, one stop bit, sent least significant bit first. Four wires leave the block: serial out, serial in, and active-low request-to-send and clear-to-send. Bytes from the host side go into a transmit FIFO through a valid/ready handshake. Received bytes come out of a receive FIFO through a second valid/ready handshake.

The bit rate comes from a divisor. The divisor counts either the block clock (fast reference) or every second block clock (slow reference). The 16x oversample tick fires every `divisor+1` reference pulses, so one bit lasts `16*(divisor+1)` clocks on the fast reference and twice that on the slow one. The default divisor of 25 on a 48 MHz fast reference gives about 115200 baud out of reset. Software can load the whole divisor in one write, or write its high byte and low byte separately. A new value waits in a shadow register and takes effect only when both directions sit between frames.

Flow control is done in hardware. A byte leaves only while the clear-to-send input is low. The receiver raises request-to-send when its FIFO runs short of space and lowers it again once enough space has been drained. Two sticky error flags are provided: one for a missing stop bit and one for a byte that arrived into a full receive FIFO.

Top module: `hci_uart`

## Requirements
- R1: After reset, serial out is high, request-to-send is low (asserted), the receive side shows no valid byte, the transmit side is ready, and both error flags are low.
- R2: Each transmitted frame is a low start bit, then eight data bits least significant first, then a high stop bit. Every bit lasts exactly 16*(divisor+1) clocks when the fast reference is selected.
- R3: A frame starts only while the synchronised clear-to-send is low. While clear-to-send is held high, serial out stays high. After clear-to-send falls, the start bit begins within 24 bit periods.
- R4: The receiver oversamples at 16x and samples each bit at its centre. It decodes frames whose bit period is off nominal by up to about 3% in either direction, which is its share of a ±5% combined link error.
- R5: A stop bit sampled low sets the sticky frame_err flag. That byte is discarded, and the receiver waits for the line to go high before it looks for the next start bit.
- R6: Request-to-send goes high once fewer than 4 receive entries are free, well within 2 bit periods of the stop-bit centre. It goes low again only once 16 or more entries are free; between those points it keeps its level.
- R7: A byte completed while the receive FIFO is full is dropped, and the sticky overflow flag is set.
- R8: Both FIFOs keep byte order. in_ready drops after TX_DEPTH bytes are queued and nothing has been sent.
- R9: cfg_kind 0 writes the whole divisor and the reference select. cfg_kind 1 writes the divisor's high byte and cfg_kind 2 its low byte; each byte write leaves the other byte as it was.
- R10: A divisor write made while a frame is on the wire leaves that frame at the old rate. The new rate applies from the next frame on.
- R11: With cfg_slow set on a full write, every bit lasts 32*(divisor+1) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the fast baud reference |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | 8 | Byte to transmit |
| in_valid | input | 1 | in_data is offered |
| in_ready | output | 1 | Transmit FIFO has room |
| out_data | output | 8 | Oldest received byte |
| out_valid | output | 1 | Receive FIFO not empty |
| out_ready | input | 1 | Consumer takes out_data this cycle |
| cfg_wr | input | 1 | Divisor write strobe |
| cfg_kind | input | 2 | 0 whole divisor, 1 high byte, 2 low byte |
| cfg_wdata | input | DIV_W | Write value (byte writes use bits 7:0) |
| cfg_slow | input | 1 | Reference select on a whole write, 1 = slow |
| uart_txd | output | 1 | Serial out |
| uart_rxd | input | 1 | Serial in |
| uart_rts_n | output | 1 | Request-to-send, active low |
| uart_cts_n | input | 1 | Clear-to-send, active low |
| frame_err | output | 1 | Sticky bad-stop-bit flag |
| overflow | output | 1 | Sticky receive-overflow flag |

## Verification
The bench uses a default divisor of 3, so a bit is 64 clocks. That keeps the frame loops and the ±3% off-rate frames short. Both FIFOs are built 20 entries deep. With that depth, seventeen received bytes cross the request-to-send threshold, three more fill the FIFO, and one extra byte reaches the overflow path; a full transmit FIFO needs only twenty pushes. The 16-free-entry release point then sits at a fill of four, so the hysteresis band can be walked down one pop at a time.

// File: rtl/hci_uart_pkg.sv
package hci_uart_pkg;
   localparam int OVS = 16;

   typedef enum logic [1:0] {
      CFG_FULL = 2'd0,
      CFG_HI   = 2'd1,
      CFG_LO   = 2'd2
   } cfg_kind_e;

   typedef enum logic [2:0] {
      RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_BRK
   } rx_st_e;
endpackage

// File: rtl/hci_uart_fifo.sv
module hci_uart_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   input  logic          pop,
   output logic [W-1:0]  rdata,
   output logic          full,
   output logic          empty,
   output logic [CW-1:0] count
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr, wnext, rnext;
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rptr];

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign wnext = wptr + 1'b1;
         assign rnext = rptr + 1'b1;
      end else begin : g_wrap
         assign wnext = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         assign rnext = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= wnext;
         if (do_pop)  rptr <= rnext;
         if (do_push && !do_pop)      count <= count + 1'b1;
         else if (do_pop && !do_push) count <= count - 1'b1;
      end
   end
endmodule

// File: rtl/hci_uart_baud.sv
module hci_uart_baud
   import hci_uart_pkg::*;
#(
   parameter int DIV_W    = 16,
   parameter int DEF_DIV  = 25,
   parameter bit DEF_SLOW = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [1:0]       cfg_kind,
   input  logic [DIV_W-1:0] cfg_wdata,
   input  logic             cfg_slow,
   input  logic             tx_idle,
   input  logic             rx_idle,
   output logic             tick,
   output logic             pend,
   output logic [DIV_W-1:0] act_div
);
   logic [DIV_W-1:0] shd_div, cnt;
   logic             shd_slow, act_slow, half, ref_en, apply;

   assign ref_en = !act_slow || half;
   assign tick   = ref_en && (cnt == act_div);
   assign apply  = pend && tx_idle && rx_idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shd_div  <= DIV_W'(DEF_DIV);
         shd_slow <= DEF_SLOW;
         act_div  <= DIV_W'(DEF_DIV);
         act_slow <= DEF_SLOW;
         pend     <= 1'b0;
         half     <= 1'b0;
         cnt      <= '0;
      end else begin
         if (apply) begin
            act_div  <= shd_div;
            act_slow <= shd_slow;
            pend     <= 1'b0;
            half     <= 1'b0;
            cnt      <= '0;
         end else begin
            half <= ~half;
            if (ref_en) cnt <= (cnt == act_div) ? '0 : cnt + 1'b1;
         end
         if (cfg_wr) begin
            case (cfg_kind)
               CFG_FULL: begin
                  shd_div  <= cfg_wdata;
                  shd_slow <= cfg_slow;
                  pend     <= 1'b1;
               end
               CFG_HI: begin
                  shd_div[DIV_W-1:8] <= cfg_wdata[DIV_W-9:0];
                  pend               <= 1'b1;
               end
               CFG_LO: begin
                  shd_div[7:0] <= cfg_wdata[7:0];
                  pend         <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/hci_uart_tx.sv
module hci_uart_tx
   import hci_uart_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       go_ok,
   input  logic       src_valid,
   input  logic [7:0] src_data,
   output logic       pop,
   output logic       txd,
   output logic       idle
);
   logic       busy;
   logic [8:0] sh;
   logic [3:0] ph;
   logic [3:0] nbit;

   assign pop  = !busy && tick && go_ok && src_valid;
   assign idle = !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         txd  <= 1'b1;
         sh   <= '1;
         ph   <= '0;
         nbit <= '0;
      end else if (pop) begin
         busy <= 1'b1;
         txd  <= 1'b0;
         sh   <= {1'b1, src_data};
         ph   <= '0;
         nbit <= '0;
      end else if (busy && tick) begin
         if (ph == 4'(OVS - 1)) begin
            ph <= '0;
            if (nbit == 4'd9) begin
               busy <= 1'b0;
            end else begin
               txd  <= sh[0];
               sh   <= {1'b1, sh[8:1]};
               nbit <= nbit + 1'b1;
            end
         end else begin
            ph <= ph + 1'b1;
         end
      end
   end
endmodule

// File: rtl/hci_uart_rx.sv
module hci_uart_rx
   import hci_uart_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rxd,
   output logic       byte_v,
   output logic [7:0] byte_d,
   output logic       ferr,
   output logic       idle
);
   rx_st_e     st;
   logic [3:0] cnt;
   logic [2:0] nbit;

   assign idle = (st == RX_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= RX_IDLE;
         cnt    <= '0;
         nbit   <= '0;
         byte_d <= '0;
         byte_v <= 1'b0;
         ferr   <= 1'b0;
      end else begin
         byte_v <= 1'b0;
         ferr   <= 1'b0;
         case (st)
            RX_IDLE: if (tick && !rxd) begin
               st  <= RX_START;
               cnt <= '0;
            end
            RX_START: if (tick) begin
               if (cnt == 4'(OVS/2 - 1)) begin
                  st   <= rxd ? RX_IDLE : RX_DATA;
                  cnt  <= '0;
                  nbit <= '0;
               end else cnt <= cnt + 1'b1;
            end
            RX_DATA: if (tick) begin
               if (cnt == 4'(OVS - 1)) begin
                  cnt    <= '0;
                  byte_d <= {rxd, byte_d[7:1]};
                  if (nbit == 3'd7) st <= RX_STOP;
                  else nbit <= nbit + 1'b1;
               end else cnt <= cnt + 1'b1;
            end
            RX_STOP: if (tick) begin
               if (cnt == 4'(OVS - 1)) begin
                  cnt <= '0;
                  if (rxd) begin
                     byte_v <= 1'b1;
                     st     <= RX_IDLE;
                  end else begin
                     ferr <= 1'b1;
                     st   <= RX_BRK;
                  end
               end else cnt <= cnt + 1'b1;
            end
            RX_BRK: if (rxd) st <= RX_IDLE;
            default: st <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hci_uart.sv
module hci_uart #(
   parameter int DIV_W        = 16,
   parameter int DEF_DIV      = 25,
   parameter bit DEF_SLOW     = 1'b0,
   parameter int TX_DEPTH     = 480,
   parameter int RX_DEPTH     = 480,
   parameter int RTS_OFF_FREE = 4,
   parameter int RTS_ON_FREE  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       in_data,
   input  logic             in_valid,
   output logic             in_ready,
   output logic [7:0]       out_data,
   output logic             out_valid,
   input  logic             out_ready,
   input  logic             cfg_wr,
   input  logic [1:0]       cfg_kind,
   input  logic [DIV_W-1:0] cfg_wdata,
   input  logic             cfg_slow,
   output logic             uart_txd,
   input  logic             uart_rxd,
   output logic             uart_rts_n,
   input  logic             uart_cts_n,
   output logic             frame_err,
   output logic             overflow
);
   localparam int TCW = $clog2(TX_DEPTH + 1);
   localparam int RCW = $clog2(RX_DEPTH + 1);

   generate
      if (DIV_W < 9 || DIV_W > 16) begin : g_bad_divw
         $error("DIV_W must lie in 9..16");
      end
      if (DEF_DIV < 0 || DEF_DIV >= (1 << DIV_W)) begin : g_bad_def
         $error("DEF_DIV does not fit DIV_W");
      end
      if (RTS_ON_FREE <= RTS_OFF_FREE || RX_DEPTH < RTS_ON_FREE) begin : g_bad_rts
         $error("need RTS_OFF_FREE < RTS_ON_FREE <= RX_DEPTH");
      end
      if (TX_DEPTH < 2) begin : g_bad_tx
         $error("TX_DEPTH must be at least 2");
      end
   endgenerate

   logic [1:0]       cts_q, rxd_q;
   logic             cts_s, rxd_s;
   logic             tick, pend, tx_idle, rx_idle, tx_pop, go_ok;
   logic [DIV_W-1:0] act_div;
   logic [7:0]       tx_head, rx_byte;
   logic             tx_full, tx_empty, rx_full, rx_empty;
   logic [TCW-1:0]   tx_count;
   logic [RCW-1:0]   rx_count, rx_free;
   logic             rx_v, rx_ferr, rx_push;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cts_q <= 2'b11;
         rxd_q <= 2'b11;
      end else begin
         cts_q <= {cts_q[0], uart_cts_n};
         rxd_q <= {rxd_q[0], uart_rxd};
      end
   end
   assign cts_s = cts_q[1];
   assign rxd_s = rxd_q[1];
   assign go_ok = !cts_s && !pend;

   hci_uart_baud #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV), .DEF_SLOW(DEF_SLOW)) u_baud (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_kind(cfg_kind),
      .cfg_wdata(cfg_wdata), .cfg_slow(cfg_slow), .tx_idle(tx_idle),
      .rx_idle(rx_idle), .tick(tick), .pend(pend), .act_div(act_div));

   hci_uart_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(in_valid), .wdata(in_data),
      .pop(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty),
      .count(tx_count));
   assign in_ready = !tx_full;

   hci_uart_tx u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .go_ok(go_ok),
      .src_valid(!tx_empty), .src_data(tx_head), .pop(tx_pop),
      .txd(uart_txd), .idle(tx_idle));

   hci_uart_rx u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd_s),
      .byte_v(rx_v), .byte_d(rx_byte), .ferr(rx_ferr), .idle(rx_idle));

   assign rx_push = rx_v && !rx_full;

   hci_uart_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_byte),
      .pop(out_ready), .rdata(out_data), .full(rx_full), .empty(rx_empty),
      .count(rx_count));
   assign out_valid = !rx_empty;
   assign rx_free   = RCW'(RX_DEPTH) - rx_count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         uart_rts_n <= 1'b0;
         frame_err  <= 1'b0;
         overflow   <= 1'b0;
      end else begin
         if (rx_free < RCW'(RTS_OFF_FREE))       uart_rts_n <= 1'b1;
         else if (rx_free >= RCW'(RTS_ON_FREE))  uart_rts_n <= 1'b0;
         if (rx_ferr)          frame_err <= 1'b1;
         if (rx_v && rx_full)  overflow  <= 1'b1;
      end
   end
endmodule

// File: rtl/hci_uart_chk.sv
module hci_uart_chk #(
   parameter int DIV_W        = 16,
   parameter int RX_DEPTH     = 480,
   parameter int RTS_OFF_FREE = 4,
   parameter int RTS_ON_FREE  = 16,
   localparam int RCW         = $clog2(RX_DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tx_pop,
   input logic             cts_s,
   input logic [RCW-1:0]   rx_count,
   input logic             uart_rts_n,
   input logic             rx_v,
   input logic             rx_full,
   input logic             overflow,
   input logic             frame_err,
   input logic [DIV_W-1:0] act_div,
   input logic             tx_idle,
   input logic             rx_idle
);
   AST_TX_NEEDS_CTS: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |-> !cts_s);  // R3
   AST_RTS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count > RCW'(RX_DEPTH - RTS_OFF_FREE)) |=> uart_rts_n);  // R6
   AST_RTS_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count <= RCW'(RX_DEPTH - RTS_ON_FREE)) |=> !uart_rts_n);  // R6
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_v && rx_full) |=> overflow);  // R7
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);  // R7
   AST_FRM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> frame_err);  // R5
   AST_DIV_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_div) |-> $past(tx_idle && rx_idle));  // R10
endmodule

bind hci_uart hci_uart_chk #(
   .DIV_W(DIV_W), .RX_DEPTH(RX_DEPTH),
   .RTS_OFF_FREE(RTS_OFF_FREE), .RTS_ON_FREE(RTS_ON_FREE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tx_pop(tx_pop), .cts_s(cts_s),
   .rx_count(rx_count), .uart_rts_n(uart_rts_n), .rx_v(rx_v),
   .rx_full(rx_full), .overflow(overflow), .frame_err(frame_err),
   .act_div(act_div), .tx_idle(tx_idle), .rx_idle(rx_idle));

// File: tb/sim_hci_uart.sv
module sim_hci_uart;
   localparam int DIV_W = 16;
   localparam int DEPTH = 20;
   localparam int BIT   = 64;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [7:0]       in_data = '0;
   logic             in_valid = 1'b0;
   logic             in_ready;
   logic [7:0]       out_data;
   logic             out_valid;
   logic             out_ready = 1'b0;
   logic             cfg_wr = 1'b0;
   logic [1:0]       cfg_kind = '0;
   logic [DIV_W-1:0] cfg_wdata = '0;
   logic             cfg_slow = 1'b0;
   logic             txd;
   logic             rxd = 1'b1;
   logic             rts_n;
   logic             cts_n = 1'b1;
   logic             frame_err, overflow;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   hci_uart #(.DIV_W(DIV_W), .DEF_DIV(3), .TX_DEPTH(DEPTH), .RX_DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
      .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
      .out_ready(out_ready), .cfg_wr(cfg_wr), .cfg_kind(cfg_kind),
      .cfg_wdata(cfg_wdata), .cfg_slow(cfg_slow), .uart_txd(txd),
      .uart_rxd(rxd), .uart_rts_n(rts_n), .uart_cts_n(cts_n),
      .frame_err(frame_err), .overflow(overflow));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic push(input logic [7:0] d);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = d;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic pop(output logic [7:0] d, output bit got);
      @(negedge clk);
      got = out_valid;
      d = out_data;
      out_ready = got;
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   task automatic cfg(input logic [1:0] kind, input int val, input bit slow);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_kind = kind; cfg_wdata = DIV_W'(val); cfg_slow = slow;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic send_rx(input logic [7:0] b, input int per, input bit stop);
      @(negedge clk);
      rxd = 1'b0;
      repeat (per) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rxd = b[i];
         repeat (per) @(negedge clk);
      end
      rxd = stop;
      repeat (per) @(negedge clk);
      rxd = 1'b1;
      repeat (per) @(negedge clk);
   endtask

   // Decodes one frame; data bit 0 must be 1 so the low run measures one bit.
   task automatic grab(input int per, input int new_div, output logic [7:0] b,
                       output int meas, output int c0);
      bit stop_ok;
      while (txd) @(negedge clk);
      c0 = cyc;
      if (new_div >= 0) begin
         cfg_wr = 1'b1; cfg_kind = 2'd0; cfg_wdata = DIV_W'(new_div); cfg_slow = 1'b0;
      end
      meas = 0;
      while (!txd && meas < per * 4) begin
         @(negedge clk);
         cfg_wr = 1'b0;
         meas++;
      end
      b[0] = 1'b1;
      for (int k = 1; k < 8; k++) begin
         wait_until(c0 + per * (k + 1) + per / 2);
         b[k] = txd;
      end
      wait_until(c0 + per * 9 + per / 2);
      stop_ok = txd;
      check(stop_ok, "R2 stop bit", int'(stop_ok), 1);
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      check(txd == 1'b1, "R1 txd idle", int'(txd), 1);
      check(rts_n == 1'b0, "R1 rts asserted", int'(rts_n), 0);
      check(out_valid == 1'b0, "R1 no rx byte", int'(out_valid), 0);
      check(in_ready == 1'b1, "R1 tx ready", int'(in_ready), 1);
      check(frame_err == 1'b0 && overflow == 1'b0, "R1 flags clear",
            int'({frame_err, overflow}), 0);
   endtask

   task automatic t_tx_frame;
      logic [7:0] b; int m, c0;
      cts_n = 1'b0;
      push(8'hA5);
      push(8'h3B);
      grab(BIT, -1, b, m, c0);
      check(b == 8'hA5, "R2 data lsb first", int'(b), 'hA5);
      check(m == BIT, "R2 bit period", m, BIT);
      grab(BIT, -1, b, m, c0);
      check(b == 8'h3B, "R2 second frame", int'(b), 'h3B);
   endtask

   task automatic t_cts_gate;
      logic [7:0] b; int m, c0, c1; bit stayed;
      repeat (BIT * 2) @(negedge clk);
      cts_n = 1'b1;
      repeat (4) @(negedge clk);
      push(8'h81);
      stayed = 1'b1;
      repeat (BIT * 20) begin
         @(negedge clk);
         if (!txd) stayed = 1'b0;
      end
      check(stayed, "R3 held while cts high", int'(stayed), 1);
      cts_n = 1'b0;
      c1 = cyc;
      grab(BIT, -1, b, m, c0);
      check(c0 - c1 <= 24 * BIT, "R3 start latency", c0 - c1, 24 * BIT);
      check(b == 8'h81, "R3 data after cts", int'(b), 'h81);
   endtask

   task automatic t_rx_basic;
      logic [7:0] d; bit g;
      send_rx(8'h5A, BIT, 1'b1);
      send_rx(8'hC3, BIT - 2, 1'b1);
      send_rx(8'h0F, BIT + 2, 1'b1);
      pop(d, g); check(g && d == 8'h5A, "R4 nominal rate", int'(d), 'h5A);
      pop(d, g); check(g && d == 8'hC3, "R4 fast sender", int'(d), 'hC3);
      pop(d, g); check(g && d == 8'h0F, "R4 slow sender", int'(d), 'h0F);
      check(!out_valid, "R8 rx fifo drained", int'(out_valid), 0);
   endtask

   task automatic t_frame_err;
      logic [7:0] d; bit g;
      send_rx(8'h77, BIT, 1'b0);
      check(frame_err == 1'b1, "R5 flag set", int'(frame_err), 1);
      check(out_valid == 1'b0, "R5 byte dropped", int'(out_valid), 0);
      send_rx(8'h2D, BIT, 1'b1);
      pop(d, g);
      check(g && d == 8'h2D, "R5 next byte ok", int'(d), 'h2D);
      check(frame_err == 1'b1, "R5 flag sticky", int'(frame_err), 1);
   endtask

   task automatic t_rts_ovf;
      logic [7:0] d; bit g; bit order_ok;
      for (int i = 0; i < 16; i++) send_rx(8'(8'h40 + i), BIT, 1'b1);
      check(rts_n == 1'b0, "R6 rts low at 4 free", int'(rts_n), 0);
      send_rx(8'h50, BIT, 1'b1);
      check(rts_n == 1'b1, "R6 rts high within 2 bits", int'(rts_n), 1);
      for (int i = 17; i < 20; i++) send_rx(8'(8'h40 + i), BIT, 1'b1);
      check(overflow == 1'b0, "R7 no overflow at full", int'(overflow), 0);
      send_rx(8'hEE, BIT, 1'b1);
      check(overflow == 1'b1, "R7 overflow flag", int'(overflow), 1);
      order_ok = 1'b1;
      for (int i = 0; i < 15; i++) begin
         pop(d, g);
         if (!g || d != 8'(8'h40 + i)) order_ok = 1'b0;
      end
      repeat (3) @(negedge clk);
      check(rts_n == 1'b1, "R6 hysteresis at 15 free", int'(rts_n), 1);
      pop(d, g);
      if (!g || d != 8'h4F) order_ok = 1'b0;
      repeat (3) @(negedge clk);
      check(rts_n == 1'b0, "R6 rts low at 16 free", int'(rts_n), 0);
      for (int i = 16; i < 20; i++) begin
         pop(d, g);
         if (!g || d != 8'(8'h40 + i)) order_ok = 1'b0;
      end
      check(order_ok, "R8 rx order", int'(order_ok), 1);
      check(out_valid == 1'b0, "R7 extra byte dropped", int'(out_valid), 0);
   endtask

   task automatic t_tx_full;
      logic [7:0] b; int m, c0, acc; bit order_ok;
      cts_n = 1'b1;
      repeat (BIT * 12) @(negedge clk);
      acc = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_data = 8'(2 * i + 1);
         if (in_ready) acc++;
      end
      @(negedge clk);
      in_valid = 1'b0;
      check(acc == DEPTH, "R8 tx fifo capacity", acc, DEPTH);
      cts_n = 1'b0;
      order_ok = 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
         grab(BIT, -1, b, m, c0);
         if (b != 8'(2 * i + 1)) order_ok = 1'b0;
      end
      check(order_ok, "R8 tx order", int'(order_ok), 1);
   endtask

   task automatic t_div;
      logic [7:0] b; int m, c0;
      repeat (BIT * 2) @(negedge clk);
      cfg(2'd0, 7, 1'b0);
      push(8'h01);
      grab(128, -1, b, m, c0);
      check(m == 128, "R9 full divisor write", m, 128);
      cfg(2'd1, 0, 1'b0);
      cfg(2'd2, 1, 1'b0);
      push(8'h03);
      grab(32, -1, b, m, c0);
      check(m == 32 && b == 8'h03, "R9 legacy byte writes", m, 32);
      cfg(2'd0, 3, 1'b1);
      push(8'h05);
      grab(128, -1, b, m, c0);
      check(m == 128 && b == 8'h05, "R11 slow reference", m, 128);
      cfg(2'd0, 3, 1'b0);
      push(8'h11);
      push(8'h33);
      grab(BIT, 7, b, m, c0);
      check(m == BIT && b == 8'h11, "R10 frame keeps old rate", m, BIT);
      grab(128, -1, b, m, c0);
      check(m == 128 && b == 8'h33, "R10 next frame new rate", m, 128);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_tx_frame();
      t_cts_gate();
      t_rx_basic();
      t_frame_err();
      t_rts_ovf();
      t_tx_full();
      t_div();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule